// File: doc/BRIEF.md
# Memory Fault Capture Unit

This unit sits beside a memory arbiter and its address translator. Each cycle either of them may hand it one rejected transaction. The report carries the requesting client, a physical address of up to 34 bits, the direction, whether the access was secure, a three-bit cause code and the three attribute flags of the page that was hit. The report also names the interrupt status bit it belongs to. The unit keeps one snapshot of the failing transaction. It sets one sticky status bit per fault class and drives a single interrupt line, which software services through a four-word register window.

Only the first fault is recorded. While any status bit is still pending, the snapshot stays frozen, so the record software reads always belongs to the oldest unserviced fault. Later faults still set their own status bits. Software reads the snapshot, then writes ones to the status bits to clear them, and the next fault after that is captured fresh.

Top module: `mem_fault_capture`

## Requirements
- R1: After reset the status, mask, fault word and fault address registers all read zero, and `irq` is low.
- R2: A report with `rpt_valid` high sets status bit `rpt_bit` on the next clock edge when that bit is one of the implemented classes (bits 6, 7, 8, 9, 10, 12, 13). A report naming any other bit changes no status bit and captures no record.
- R3: Status is write-one-to-clear. Writing word offset 0x00 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When a report sets a status bit in the same cycle that a bus write clears it, the bit ends up set.
- R5: `irq` is high exactly when some status bit is set and its mask bit (offset 0x04) is also set. It follows a status or mask change on the same edge that updates those registers.
- R6: The mask register at offset 0x04 is readable and writable. Only the implemented class bits are stored; every other bit reads 0.
- R7: The fault word at offset 0x08 holds the cause code in bits 30:28, the secure flag in bit 17 and the direction in bit 16 (1 = write, 0 = read). Bits 31, 24:22, 19:18 read zero.
- R8: Bits 27 (readable), 26 (writable) and 25 (non-secure) of the fault word carry the page flags only when the cause code is 6. For any other cause they read zero.
- R9: Bits 15:0 of the fault word hold the client ID ANDed with the `CLIENT_MASK` parameter.
- R10: Offset 0x0C holds physical address bits 31:0, and fault word bits 21:20 hold address bits 33:32.
- R11: The record is captured only by a report that arrives while no status bit is pending. While any bit is pending, later reports leave both record registers unchanged. Once every bit has been cleared, the next report is captured.
- R12: The fault word and fault address are read-only. Bus writes to 0x08 and 0x0C leave them unchanged.
- R13: A read of any offset other than 0x00, 0x04, 0x08 and 0x0C returns zero, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid | input | 1 | A fault report is present this cycle |
| rpt_bit | input | 5 | Status bit index of the fault class |
| rpt_cause | input | 3 | Cause code stored in the fault word |
| rpt_client | input | CLIENT_W | Requesting client ID |
| rpt_addr | input | PA_W | Faulting physical address |
| rpt_write | input | 1 | 1 for a write access, 0 for a read |
| rpt_secure | input | 1 | Access was secure |
| rpt_pg_rd | input | 1 | Page readable flag |
| rpt_pg_wr | input | 1 | Page writable flag |
| rpt_pg_ns | input | 1 | Page non-secure flag |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | BUS_AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends a report on each of the 32 status indices. A unit that decodes the implemented set wrongly would either raise a class that does not exist or drop a real one, and a capture on an ignored index would show up as a record change. It runs every cause code against every page-flag pattern, so a unit that leaks the page flags outside cause 6, or places a field at the wrong bit, gives a wrong word. The bench also lines up a report and a clear of the same bit in one cycle, where a clear-first unit would lose the fault. Finally it sends a second fault while the first is still pending, which exposes a unit that overwrites the record or fails to re-arm after the last clear.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned BIT_IDX_W = 5;

   // register offsets (bytes)
   localparam logic [7:0] OFS_STAT = 8'h00;
   localparam logic [7:0] OFS_MASK = 8'h04;
   localparam logic [7:0] OFS_WORD = 8'h08;
   localparam logic [7:0] OFS_ADDR = 8'h0C;

   // fault word field positions
   localparam int unsigned CAUSE_LSB = 28;
   localparam int unsigned PERM_LSB  = 25;
   localparam int unsigned AHI_LSB   = 20;
   localparam int unsigned SEC_POS   = 17;
   localparam int unsigned DIR_POS   = 16;

   localparam logic [2:0] CAUSE_XLATE = 3'd6;

   typedef struct packed {
      logic [2:0]  cause;
      logic [2:0]  perm;
      logic [1:0]  addr_hi;
      logic        secure;
      logic        write;
      logic [15:0] client;
   } fault_rec_t;

   function automatic logic [WORD_W-1:0] pack_word(input fault_rec_t r);
      logic [WORD_W-1:0] w;
      w = '0;
      w[CAUSE_LSB +: 3] = r.cause;
      w[PERM_LSB +: 3]  = r.perm;
      w[AHI_LSB +: 2]   = r.addr_hi;
      w[SEC_POS]        = r.secure;
      w[DIR_POS]        = r.write;
      w[15:0]           = r.client;
      return w;
   endfunction
endpackage

// File: rtl/mfc_status_bank.sv
module mfc_status_bank #(
   parameter int unsigned     N_BITS   = 32,
   parameter logic [N_BITS-1:0] IMPL_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BITS-1:0] set_vec,
   input  logic [N_BITS-1:0] clr_vec,
   input  logic              mask_we,
   input  logic [N_BITS-1:0] mask_wdata,
   output logic [N_BITS-1:0] stat_q,
   output logic [N_BITS-1:0] mask_q
);
   for (genvar i = 0; i < N_BITS; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stat_q[i] <= 1'b0;
               mask_q[i] <= 1'b0;
            end else begin
               // a new fault wins over a clear in the same cycle
               stat_q[i] <= (stat_q[i] & ~clr_vec[i]) | set_vec[i];
               if (mask_we) mask_q[i] <= mask_wdata[i];
            end
         end
      end else begin : g_tied
         assign stat_q[i] = 1'b0;
         assign mask_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/mfc_record.sv
module mfc_record
   import mfc_pkg::*;
#(
   parameter int unsigned  CLIENT_W    = 7,
   parameter int unsigned  PA_W        = 34,
   parameter logic [15:0]  CLIENT_MASK = 16'h007F
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic [2:0]          cause,
   input  logic [CLIENT_W-1:0] client,
   input  logic [PA_W-1:0]     addr,
   input  logic                write,
   input  logic                secure,
   input  logic [2:0]          perm,
   output logic [WORD_W-1:0]   word_q,
   output logic [31:0]         addr_q
);
   localparam int unsigned HI_W = PA_W - 32;

   fault_rec_t        rec;
   logic [1:0]        hi_bits;
   logic [15:0]       client_ext;

   if (HI_W > 0) begin : g_hi
      assign hi_bits = 2'(addr[PA_W-1:32]);
   end else begin : g_nohi
      assign hi_bits = 2'b00;
   end

   assign client_ext = 16'(client) & CLIENT_MASK;

   always_comb begin
      rec.cause   = cause;
      rec.perm    = (cause == CAUSE_XLATE) ? perm : 3'b000;
      rec.addr_hi = hi_bits;
      rec.secure  = secure;
      rec.write   = write;
      rec.client  = client_ext;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         addr_q <= '0;
      end else if (capture) begin
         word_q <= pack_word(rec);
         addr_q <= addr[31:0];
      end
   end
endmodule

// File: rtl/mfc_regbus.sv
module mfc_regbus
   import mfc_pkg::*;
#(
   parameter int unsigned BUS_AW = 8
) (
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       stat_q,
   input  logic [31:0]       mask_q,
   input  logic [31:0]       word_q,
   input  logic [31:0]       addr_q,
   output logic              stat_we,
   output logic              mask_we,
   output logic [31:0]       rdata
);
   logic hit_stat, hit_mask, hit_word, hit_addr;

   assign hit_stat = (bus_addr == BUS_AW'(OFS_STAT));
   assign hit_mask = (bus_addr == BUS_AW'(OFS_MASK));
   assign hit_word = (bus_addr == BUS_AW'(OFS_WORD));
   assign hit_addr = (bus_addr == BUS_AW'(OFS_ADDR));

   assign stat_we = bus_sel & bus_we & hit_stat;
   assign mask_we = bus_sel & bus_we & hit_mask;

   always_comb begin
      rdata = '0;
      if (hit_stat) rdata = stat_q;
      if (hit_mask) rdata = mask_q;
      if (hit_word) rdata = word_q;
      if (hit_addr) rdata = addr_q;
   end
endmodule

// File: rtl/mem_fault_capture.sv
module mem_fault_capture
   import mfc_pkg::*;
#(
   parameter int unsigned  CLIENT_W    = 7,
   parameter int unsigned  PA_W        = 34,
   parameter int unsigned  BUS_AW      = 8,
   parameter logic [15:0]  CLIENT_MASK = 16'h007F,
   parameter logic [31:0]  IMPL_MASK   = 32'h0000_37C0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rpt_valid,
   input  logic [4:0]          rpt_bit,
   input  logic [2:0]          rpt_cause,
   input  logic [CLIENT_W-1:0] rpt_client,
   input  logic [PA_W-1:0]     rpt_addr,
   input  logic                rpt_write,
   input  logic                rpt_secure,
   input  logic                rpt_pg_rd,
   input  logic                rpt_pg_wr,
   input  logic                rpt_pg_ns,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [BUS_AW-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                irq
);
   if (CLIENT_W < 1 || CLIENT_W > 16) begin : g_bad_client
      $error("CLIENT_W must lie in 1..16");
   end
   if (PA_W < 32 || PA_W > 34) begin : g_bad_pa
      $error("PA_W must lie in 32..34");
   end
   if (BUS_AW < 4) begin : g_bad_aw
      $error("BUS_AW must be at least 4");
   end

   logic [31:0] set_vec, clr_vec, stat_q, mask_q, word_q, addr_q;
   logic        stat_we, mask_we, pending, capture;

   assign set_vec = rpt_valid ? ((32'd1 << rpt_bit) & IMPL_MASK) : 32'd0;
   assign clr_vec = stat_we ? bus_wdata : 32'd0;
   assign pending = |stat_q;
   assign capture = (|set_vec) & ~pending;

   mfc_status_bank #(.N_BITS(32), .IMPL_MASK(IMPL_MASK)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
      .mask_we(mask_we), .mask_wdata(bus_wdata),
      .stat_q(stat_q), .mask_q(mask_q)
   );

   mfc_record #(.CLIENT_W(CLIENT_W), .PA_W(PA_W), .CLIENT_MASK(CLIENT_MASK)) u_rec (
      .clk(clk), .rst_n(rst_n), .capture(capture), .cause(rpt_cause),
      .client(rpt_client), .addr(rpt_addr), .write(rpt_write),
      .secure(rpt_secure), .perm({rpt_pg_rd, rpt_pg_wr, rpt_pg_ns}),
      .word_q(word_q), .addr_q(addr_q)
   );

   mfc_regbus #(.BUS_AW(BUS_AW)) u_bus (
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .stat_q(stat_q), .mask_q(mask_q), .word_q(word_q), .addr_q(addr_q),
      .stat_we(stat_we), .mask_we(mask_we), .rdata(bus_rdata)
   );

   assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
   parameter logic [31:0] IMPL_MASK = 32'h0000_37C0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        rpt_valid,
   input logic [4:0]  rpt_bit,
   input logic [31:0] stat_q,
   input logic [31:0] mask_q,
   input logic [31:0] word_q,
   input logic [31:0] addr_q,
   input logic        irq
);
   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (stat_q == 32'd0 && mask_q == 32'd0 && word_q == 32'd0 && addr_q == 32'd0));

   // R4
   fault_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && IMPL_MASK[rpt_bit]) |=> stat_q[$past(rpt_bit)]);

   // R11
   record_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q != 32'd0) |=> ($stable(word_q) && $stable(addr_q)));

   // R5
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == 32'd0) |-> !irq);

   // R6
   mask_impl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q & ~IMPL_MASK) == 32'd0);

   // R8
   perm_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_q[30:28] != 3'd6) |-> (word_q[27:25] == 3'b000));
endmodule

bind mem_fault_capture mfc_checker #(.IMPL_MASK(IMPL_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_bit(rpt_bit),
   .stat_q(stat_q), .mask_q(mask_q), .word_q(word_q), .addr_q(addr_q),
   .irq(irq)
);

// File: tb/sim_mem_fault_capture.sv
`timescale 1ns/1ps
module sim_mem_fault_capture;
   localparam int unsigned CW = 7;
   localparam int unsigned PW = 34;
   localparam logic [15:0] CM = 16'h003F;
   localparam logic [31:0] IMPL = 32'h0000_37C0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rpt_valid = 0, rpt_write = 0, rpt_secure = 0;
   logic rpt_pg_rd = 0, rpt_pg_wr = 0, rpt_pg_ns = 0;
   logic [4:0] rpt_bit = '0;
   logic [2:0] rpt_cause = '0;
   logic [CW-1:0] rpt_client = '0;
   logic [PW-1:0] rpt_addr = '0;
   logic bus_sel = 0, bus_we = 0;
   logic [7:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic irq;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   mem_fault_capture #(.CLIENT_W(CW), .PA_W(PW), .BUS_AW(8), .CLIENT_MASK(CM),
                       .IMPL_MASK(IMPL)) u0 (
      .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_bit(rpt_bit),
      .rpt_cause(rpt_cause), .rpt_client(rpt_client), .rpt_addr(rpt_addr),
      .rpt_write(rpt_write), .rpt_secure(rpt_secure), .rpt_pg_rd(rpt_pg_rd),
      .rpt_pg_wr(rpt_pg_wr), .rpt_pg_ns(rpt_pg_ns), .bus_sel(bus_sel),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   function automatic logic [31:0] rd(input logic [7:0] ofs);
      bus_addr = ofs;
      return bus_rdata;
   endfunction

   task automatic peek(input logic [7:0] ofs, output logic [31:0] v);
      bus_sel = 1; bus_we = 0; bus_addr = ofs; #0.5;
      v = bus_rdata; bus_sel = 0;
   endtask

   task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
      bus_sel = 1; bus_we = 1; bus_addr = ofs; bus_wdata = d;
      step();
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic report(input logic [4:0] b, input logic [2:0] c, input logic [2:0] p,
                         input logic s, input logic w, input logic [CW-1:0] cl,
                         input logic [PW-1:0] a);
      rpt_valid = 1; rpt_bit = b; rpt_cause = c;
      {rpt_pg_rd, rpt_pg_wr, rpt_pg_ns} = p;
      rpt_secure = s; rpt_write = w; rpt_client = cl; rpt_addr = a;
      step();
      rpt_valid = 0;
   endtask

   function automatic logic [31:0] exp_word(input logic [2:0] c, input logic [2:0] p,
                                            input logic s, input logic w,
                                            input logic [CW-1:0] cl, input logic [PW-1:0] a);
      logic [31:0] e;
      e = 32'd0;
      e[30:28] = c;
      e[27:25] = (c == 3'd6) ? p : 3'd0;
      e[21:20] = a[33:32];
      e[17] = s;
      e[16] = w;
      e[15:0] = 16'(cl) & CM;
      return e;
   endfunction

   initial begin
      logic [31:0] v;
      logic [31:0] w0, a0;
      repeat (3) step();
      // R1: reset state
      peek(8'h00, v); chk("R1 status", v, 0);
      peek(8'h04, v); chk("R1 mask", v, 0);
      peek(8'h08, v); chk("R1 word", v, 0);
      peek(8'h0C, v); chk("R1 addr", v, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      rst_n = 1; step();

      // R6: mask stores only implemented bits
      wr(8'h04, 32'hFFFF_FFFF);
      peek(8'h04, v); chk("R6 mask all", v, IMPL);
      wr(8'h04, 32'h0000_0000);

      // R2: sweep every status index
      for (int b = 0; b < 32; b++) begin
         report(5'(b), 3'd2, 3'd0, 0, 1, 7'h11, 34'h0_0000_1000 + 34'(b));
         peek(8'h00, v); chk("R2 status bit", v, IMPL[b] ? (32'd1 << b) : 32'd0);
         peek(8'h0C, v); chk("R2 capture", v, IMPL[b] ? (32'h1000 + b) : 32'd0);
         wr(8'h00, 32'hFFFF_FFFF);
         peek(8'h00, v); chk("R3 cleared", v, 0);
         // reset the record for the next index's capture check
         rst_n = 0; step(); rst_n = 1;
      end

      // R7 R8 R9 R10: cause x permission sweep
      for (int c = 0; c < 8; c++) begin
         for (int p = 0; p < 8; p++) begin
            logic [PW-1:0] a;
            logic [CW-1:0] cl;
            a  = {2'(p + c), 32'hA000_0000 + 32'(c * 8 + p)};
            cl = 7'(c * 17 + p * 5 + 64);
            report(5'd10, 3'(c), 3'(p), p[0], c[0], cl, a);
            peek(8'h08, v);
            chk("R7 R8 R9 fault word", v, exp_word(3'(c), 3'(p), p[0], c[0], cl, a));
            peek(8'h0C, v); chk("R10 low address", v, a[31:0]);
            wr(8'h00, 32'h0000_0400);
         end
      end

      // R11: first record held while pending, re-armed after clear
      report(5'd6, 3'd2, 3'd0, 0, 0, 7'h05, 34'h1_1111_1111);
      peek(8'h08, w0); peek(8'h0C, a0);
      report(5'd8, 3'd3, 3'd0, 1, 1, 7'h22, 34'h2_2222_2222);
      peek(8'h00, v); chk("R11 both pending", v, 32'h0000_0140);
      peek(8'h08, v); chk("R11 word held", v, w0);
      peek(8'h0C, v); chk("R11 addr held", v, a0);
      wr(8'h00, 32'h0000_0040);
      report(5'd12, 3'd4, 3'd0, 0, 0, 7'h33, 34'h3_3333_3333);
      peek(8'h0C, v); chk("R11 still held", v, a0);
      wr(8'h00, 32'hFFFF_FFFF);
      report(5'd13, 3'd4, 3'd7, 1, 0, 7'h44, 34'h0_4444_4444);
      peek(8'h0C, v); chk("R11 rearmed", v, 32'h4444_4444);
      peek(8'h08, v); chk("R11 rearmed word", v, exp_word(3'd4, 3'd7, 1, 0, 7'h44, 34'h0_4444_4444));

      // R12: record read-only
      wr(8'h08, 32'hDEAD_BEEF); wr(8'h0C, 32'hCAFE_F00D);
      peek(8'h0C, v); chk("R12 addr unchanged", v, 32'h4444_4444);
      peek(8'h08, v); chk("R12 word unchanged", v, exp_word(3'd4, 3'd7, 1, 0, 7'h44, 34'h0_4444_4444));

      // R3: zero bits leave status alone
      report(5'd7, 3'd2, 3'd0, 0, 0, 7'h01, 34'd0);
      wr(8'h00, 32'h0000_0080);
      peek(8'h00, v); chk("R3 partial clear", v, 32'h0000_2000);

      // R5: irq follows status and mask
      chk("R5 irq masked off", {31'd0, irq}, 0);
      wr(8'h04, 32'h0000_0080);
      chk("R5 irq other bit", {31'd0, irq}, 0);
      wr(8'h04, 32'h0000_2000);
      chk("R5 irq on", {31'd0, irq}, 1);

      // R4: set and clear of the same bit in one cycle
      rpt_valid = 1; rpt_bit = 5'd9; rpt_cause = 3'd2;
      bus_sel = 1; bus_we = 1; bus_addr = 8'h00; bus_wdata = 32'h0000_2200;
      step();
      rpt_valid = 0; bus_sel = 0; bus_we = 0;
      peek(8'h00, v); chk("R4 set wins", v, 32'h0000_0200);
      chk("R5 irq off after clear", {31'd0, irq}, 0);

      // R13: unmapped offsets
      wr(8'h10, 32'hFFFF_FFFF);
      peek(8'h10, v); chk("R13 unmapped read", v, 0);
      peek(8'h00, v); chk("R13 status untouched", v, 32'h0000_0200);
      peek(8'h04, v); chk("R13 mask untouched", v, 32'h0000_2000);
      peek(8'hFC, v); chk("R13 high offset", v, 0);

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule